// File: doc/BRIEF.md
# Carry-Save Shift Multiplier

This block multiplies two unsigned N-bit operands over a fixed number of clocks. It uses a row of N full-adder slices. Each slice keeps one multiplicand bit, a sum bit and a carry bit, so the running result stays in redundant sum/carry form. A carry chain across the row is never formed. On each clock the multiplier bit for that stage goes to every slice. Each slice adds its gated multiplicand bit to its sum and carry. The sum word then moves one slice toward the low end, and the bit that leaves the bottom slice is the next product bit.

The first N stages take one multiplier bit each, least significant first, and emit the low half of the product. A further N stages feed a zero multiplier bit, which drains the stored carries and emits the high half. No final carry-propagate adder is needed. The full-adder equations use only inverted and plain three-input minority functions. A caller pulses `start` with the operands present. It then waits for `done` and reads `product`, which stays constant until the next accepted start.

Top module: `csas_mult`

## Requirements
- R1: After synchronous reset, `busy` is 0, `done` is 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is 0 captures `a` and `b` on that edge, raises `busy` on the same edge and clears `done`. Operand values after that edge have no effect.
- R3: Every operation takes exactly 2N stage clocks. `busy` stays high for 2N cycles after the accepting edge, and `done` rises on the 2N-th stage edge. `busy` and `done` are never both high.
- R4: On completion, `product` equals the unsigned 2N-bit value `a*b` of the captured operands, for all operand values including 0, 1 and all-ones.
- R5: `product` and `done` hold their values unchanged from completion until the next accepted `start`.
- R6: `start` raised while `busy` is 1 is ignored. The running operation keeps its operands, its result and its 2N-cycle length.
- R7: The carry produced by the most significant slice is zero in every stage, so that slice has no carry register.
- R8: During the last N stages, the multiplier bit sent to the slices is zero. Those stages only add each slice's stored sum and carry.
- R9: A `start` in the cycle where `done` is high is accepted and begins a new operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation when not busy |
| a | input | N | Multiplicand, unsigned |
| b | input | N | Multiplier, unsigned |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | Result valid, held until next start |
| product | output | 2N | Unsigned product a*b |

## Verification
The hardest case to reach from the ports is a stored carry that has to cross several slices during the drain stages. Only then does the top-slice carry claim or a mistake in the drain phase show up in the upper product bits. All-ones operands and operands with one high bit against all-ones give the longest carry chains, so the vector table includes them. A second `start` is injected in the middle of an operation. This shows that the running operands and the cycle count are not disturbed.

// File: rtl/csas_pkg.sv
package csas_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctrl_state_e;

  // Three-input minority: high when at most one input is high.
  function automatic logic min3(input logic x, input logic y, input logic z);
    return ~((x & y) | (x & z) | (y & z));
  endfunction

endpackage

// File: rtl/csas_slice.sv
module csas_slice #(
  parameter bit HAS_CARRY = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic step,
  input  logic a_in,
  input  logic b_bit,
  input  logic sum_in,
  output logic sum_nxt
);
  import csas_pkg::*;

  logic a_q;
  logic s_q;
  logic c_q;
  logic pp;
  logic cout;

  // Full adder built from minority functions only.
  always_comb begin
    pp      = a_q & b_bit;
    cout    = ~min3(s_q, pp, c_q);
    sum_nxt = min3(cout, ~c_q, min3(s_q, pp, ~c_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= 1'b0;
      s_q <= 1'b0;
    end else if (load) begin
      a_q <= a_in;
      s_q <= 1'b0;
    end else if (step) begin
      s_q <= sum_in;
    end
  end

  generate
    if (HAS_CARRY) begin : g_carry
      always_ff @(posedge clk) begin
        if (rst || load) c_q <= 1'b0;
        else if (step)   c_q <= cout;
      end
    end else begin : g_no_carry
      assign c_q = 1'b0;
      // R7: the highest slice never produces a carry
      p_top_carry_zero_r7: assert property (@(posedge clk) disable iff (rst)
        step |-> !cout);
    end
  endgenerate

endmodule

// File: rtl/csas_ctrl.sv
module csas_ctrl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [N-1:0] b_in,
  output logic         busy,
  output logic         done,
  output logic         load,
  output logic         step,
  output logic         last,
  output logic         flush,
  output logic         bcast
);
  import csas_pkg::*;

  localparam int STAGES = 2 * N;
  localparam int CW     = $clog2(STAGES);
  localparam logic [CW-1:0] LAST_STAGE  = CW'(STAGES - 1);
  localparam logic [CW-1:0] FLUSH_START = CW'(N);

  ctrl_state_e   state;
  logic [CW-1:0] cnt;
  logic [N-1:0]  b_sr;

  always_comb begin
    load  = (state == ST_IDLE) && start;
    step  = (state == ST_RUN);
    last  = step && (cnt == LAST_STAGE);
    flush = step && (cnt >= FLUSH_START);
    bcast = b_sr[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      b_sr  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_RUN;
            cnt   <= '0;
            b_sr  <= b_in;
            busy  <= 1'b1;
            done  <= 1'b0;
          end
        end
        ST_RUN: begin
          cnt  <= cnt + 1'b1;
          b_sr <= {1'b0, b_sr[N-1:1]};
          if (cnt == LAST_STAGE) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: busy and done are exclusive
  p_busy_done_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R3: done only rises as a run ends
  p_done_after_run_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  // R6: a run is never cut short by start
  p_run_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> busy);

  // R8: drain stages see a zero multiplier bit
  p_flush_zero_r8: assert property (@(posedge clk) disable iff (rst)
    flush |-> !bcast);

endmodule

// File: rtl/csas_collect.sv
module csas_collect #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic           last,
  input  logic           bit_in,
  output logic [2*N-1:0] product
);
  localparam int PW = 2 * N;

  logic [PW-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      product <= '0;
    end else begin
      if (load)      acc <= '0;
      else if (step) acc <= {bit_in, acc[PW-1:1]};
      if (last)      product <= {bit_in, acc[PW-1:1]};
    end
  end

  // R5: the published result only changes at the end of a run
  p_product_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !last |=> $stable(product));

endmodule

// File: rtl/csas_mult.sv
module csas_mult #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);
  logic         load;
  logic         step;
  logic         last;
  logic         flush;
  logic         bcast;
  logic [N-1:0] ns;

  csas_ctrl #(.N(N)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .b_in  (b),
    .busy  (busy),
    .done  (done),
    .load  (load),
    .step  (step),
    .last  (last),
    .flush (flush),
    .bcast (bcast)
  );

  genvar j;
  generate
    for (j = 0; j < N; j++) begin : g_slice
      if (j == N - 1) begin : g_top
        csas_slice #(.HAS_CARRY(1'b0)) u_slice (
          .clk     (clk),
          .rst     (rst),
          .load    (load),
          .step    (step),
          .a_in    (a[j]),
          .b_bit   (bcast),
          .sum_in  (1'b0),
          .sum_nxt (ns[j])
        );
      end else begin : g_mid
        csas_slice #(.HAS_CARRY(1'b1)) u_slice (
          .clk     (clk),
          .rst     (rst),
          .load    (load),
          .step    (step),
          .a_in    (a[j]),
          .b_bit   (bcast),
          .sum_in  (ns[j+1]),
          .sum_nxt (ns[j])
        );
      end
    end
  endgenerate

  csas_collect #(.N(N)) u_collect (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .step    (step),
    .last    (last),
    .bit_in  (ns[0]),
    .product (product)
  );

  // R9: start with done high begins a new run
  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> (busy && !done));

  // R2: accepted start always raises busy
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  // R8: flush never happens outside a run
  p_flush_in_run_r8: assert property (@(posedge clk) disable iff (rst)
    flush |-> busy);

endmodule

// File: tb/csas_mult_test.sv
module csas_mult_test;
  localparam int N      = 8;
  localparam int PERIOD = 10;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [N-1:0]   a = '0;
  logic [N-1:0]   b = '0;
  logic           busy;
  logic           done;
  logic [2*N-1:0] product;

  int checks = 0;
  int errors = 0;

  // Each entry: {a, b}
  localparam logic [2*N-1:0] VEC [12] = '{
    16'h0000, 16'h0001, 16'h0100, 16'h0101,
    16'hFFFF, 16'hFF01, 16'h01FF, 16'h80FF,
    16'hFF80, 16'h5AA5, 16'h7F7F, 16'hC33C
  };

  csas_mult #(.N(N)) uut (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .a       (a),
    .b       (b),
    .busy    (busy),
    .done    (done),
    .product (product)
  );

  always #(PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [N-1:0] x, input logic [N-1:0] y,
                        input bit poke, output int cyc);
    @(negedge clk);
    a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a = ~x; b = ~y;   // later operand changes must not matter (R2)
    chk(busy === 1'b1, "R2", 32'(busy), 32'd1);
    chk(done === 1'b0, "R9", 32'(done), 32'd0);
    cyc = 0;
    while (done !== 1'b1 && cyc < 4 * N) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) begin
        start = 1'b1; a = 8'h11; b = 8'h22;
      end
      if (poke && cyc == 4) start = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R3: watchdog expired, actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    logic [2*N-1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0, "R1", 32'(busy), 32'd0);
    chk(done === 1'b0, "R1", 32'(done), 32'd0);
    chk(product === '0, "R1", 32'(product), 32'd0);

    // Vector table: R4 value (R7, R8 exercised by carry-heavy entries), R3 length
    for (int i = 0; i < 12; i++) begin
      logic [N-1:0] va;
      logic [N-1:0] vb;
      logic [2*N-1:0] exp;
      va  = VEC[i][2*N-1:N];
      vb  = VEC[i][N-1:0];
      exp = (2*N)'(va) * (2*N)'(vb);
      run_op(va, vb, 1'b0, cyc);
      chk(cyc == 2 * N, "R3", 32'(cyc), 32'(2 * N));
      chk(product === exp, "R4", 32'(product), 32'(exp));
      chk(busy === 1'b0, "R3", 32'(busy), 32'd0);
    end

    // R7/R8: longest drain chains, all-ones operands
    run_op(8'hFF, 8'hFF, 1'b0, cyc);
    chk(product === 16'hFE01, "R7", 32'(product), 32'hFE01);
    run_op(8'hFE, 8'hFF, 1'b0, cyc);
    chk(product === 16'hFD02, "R8", 32'(product), 32'hFD02);

    // R6: start during a run is ignored
    run_op(8'hAB, 8'hCD, 1'b1, cyc);
    chk(cyc == 2 * N, "R6", 32'(cyc), 32'(2 * N));
    chk(product === 16'h88EF, "R6", 32'(product), 32'h88EF);

    // R5: result and done held while idle
    held = product;
    repeat (7) @(negedge clk);
    chk(product === held, "R5", 32'(product), 32'(held));
    chk(done === 1'b1, "R5", 32'(done), 32'd1);

    // R9: back-to-back start from the done state
    run_op(8'h03, 8'h05, 1'b0, cyc);
    chk(product === 16'd15, "R9", 32'(product), 32'd15);

    // R1: reset mid-run returns to the idle state
    @(negedge clk);
    a = 8'h12; b = 8'h34; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy === 1'b0, "R1", 32'(busy), 32'd0);
    chk(product === '0, "R1", 32'(product), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule